// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken, for the fetch stage of a pipelined core. Each cycle the fetch stage presents a PC on the lookup port, and the block returns a taken or not-taken guess combinationally in that same cycle. Three tables of 2-bit saturating counters produce the guess. The first is a per-address table indexed by low PC bits. The second is a correlating table, indexed by the global outcome history joined with the branch's own local history. The third is a chooser table that decides which of the first two to trust for that address.

When a branch resolves, the execute stage presents the branch PC, the real outcome and the direction that was predicted for it. The block then trains every table and shifts both history structures. If the real outcome differs from the predicted direction, the block raises a flush request to the pipeline for one cycle.

Top module: `tournament_bp`

## Requirements
- R1: After reset every counter in the per-address and correlating tables holds 01 (weak not-taken), every chooser counter holds 01 (weakly favours the per-address table), and all history bits are 0. Every lookup therefore predicts not-taken and flush_o is low.
- R2: Every counter is 2 bits wide. A taken outcome adds 1 and stops at 11; a not-taken outcome subtracts 1 and stops at 00. A counter predicts taken when its MSB is 1, so a strongly held direction flips only after two consecutive opposite outcomes.
- R3: The per-address table is indexed by PC bits [LOC_IDX_W+1:2]. PCs that differ only outside these bits share an entry.
- R4: The local history table holds LH_W-bit shift registers indexed by PC bits [LH_IDX_W+1:2]. Each valid resolution shifts the actual outcome into bit 0 of the addressed register.
- R5: The GH_W-bit global history shifts the actual outcome into bit 0 on each valid resolution. It is never changed by a lookup.
- R6: The correlating table is indexed by {global history, local history}, with the global history in the upper bits, giving 2^(GH_W+LH_W) counters.
- R7: The chooser is indexed by PC bits [CHO_IDX_W+1:2]. At resolution both component predictions are read from the current state. The chooser is trained only when those two predictions differ: it moves toward 11 when the correlating table was right and toward 00 when the per-address table was right.
- R8: lk_taken_o is the MSB of the correlating counter when the chooser MSB is 1, and otherwise the MSB of the per-address counter.
- R9: When rs_valid_i is high and rs_taken_i differs from rs_pred_i, flush_o is high during the next cycle only. In every other case flush_o is low in the next cycle.
- R10: When a lookup and a resolution address the same entries in the same cycle, the lookup returns the prediction from the state before the update.
- R11: When rs_valid_i is low, no table or history changes, whatever the other resolution inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_pc_i | input | PC_W | PC being fetched |
| lk_taken_o | output | 1 | Predicted direction for lk_pc_i, same cycle |
| rs_valid_i | input | 1 | A branch resolves this cycle |
| rs_pc_i | input | PC_W | PC of the resolving branch |
| rs_taken_i | input | 1 | Actual outcome |
| rs_pred_i | input | 1 | Direction that was predicted for it |
| flush_o | output | 1 | Misprediction flush request, one cycle |

## Verification
The branch patterns are chosen so that each one separates a different part of the block:
- A branch that is always taken and then always not-taken exercises the hysteresis and saturation of the per-address counters.
- A strictly alternating branch and a branch with a period-three pattern can only be learned through the history-indexed table, so they force the chooser to switch over.
- Aliasing PCs and lookups that address the same entries a resolution is training show whether the index slices are right and whether a lookup reads the state from before the update.
- Idle cycles with garbage on the resolution inputs, random predicted directions, and a long random mix over many PCs check the flush rule and catch any drift from a cycle-accurate reference model.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;

  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'd1;
    else       return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic [IDX_W-1:0] up_idx_i,
  output ctr_t             up_ctr_o,
  input  logic             up_en_i,
  input  logic             up_taken_i
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= CTR_WEAK_NT;
    end else if (up_en_i) begin
      mem_q[up_idx_i] <= ctr_step(mem_q[up_idx_i], up_taken_i);
    end
  end

  // read port sees pre-update state
  assign rd_ctr_o = mem_q[rd_idx_i];
  assign up_ctr_o = mem_q[up_idx_i];

  // R2
  sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_en_i && up_taken_i && (up_ctr_o == 2'b11) |=> mem_q[$past(up_idx_i)] == 2'b11);
  // R2
  sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_en_i && !up_taken_i && (up_ctr_o == 2'b00) |=> mem_q[$past(up_idx_i)] == 2'b00);
endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned HIST_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic [IDX_W-1:0]  up_idx_i,
  output logic [HIST_W-1:0] up_hist_o,
  input  logic              up_en_i,
  input  logic              up_bit_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem_q [DEPTH];
  logic [HIST_W:0]   shifted;

  assign shifted = {mem_q[up_idx_i], up_bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (up_en_i) begin
      mem_q[up_idx_i] <= shifted[HIST_W-1:0];
    end
  end

  assign rd_hist_o = mem_q[rd_idx_i];
  assign up_hist_o = mem_q[up_idx_i];

  // R4
  lhist_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_en_i |=> mem_q[$past(up_idx_i)][0] == $past(up_bit_i));
endmodule

// File: rtl/bp_ghr.sv
module bp_ghr #(
  parameter int unsigned HIST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W:0]   shifted;

  assign shifted = {hist_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hist_q <= '0;
    else if (shift_en_i) hist_q <= shifted[HIST_W-1:0];
  end

  assign hist_o = hist_q;

  // R5
  ghr_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> hist_q[0] == $past(bit_i));
  // R5
  ghr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(hist_q));
endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
  import bp_pkg::*;
#(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned PC_LSB    = 2,
  parameter int unsigned LOC_IDX_W = 6,
  parameter int unsigned CHO_IDX_W = 6,
  parameter int unsigned LH_IDX_W  = 5,
  parameter int unsigned GH_W      = 4,
  parameter int unsigned LH_W      = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            lk_taken_o,
  input  logic            rs_valid_i,
  input  logic [PC_W-1:0] rs_pc_i,
  input  logic            rs_taken_i,
  input  logic            rs_pred_i,
  output logic            flush_o
);
  localparam int unsigned COR_IDX_W = GH_W + LH_W;

  logic unused_pc;
  assign unused_pc = ^{lk_pc_i, rs_pc_i};

  // index slices
  logic [LOC_IDX_W-1:0] lk_loc_idx, rs_loc_idx;
  logic [CHO_IDX_W-1:0] lk_cho_idx, rs_cho_idx;
  logic [LH_IDX_W-1:0]  lk_lh_idx,  rs_lh_idx;
  assign lk_loc_idx = lk_pc_i[PC_LSB +: LOC_IDX_W];
  assign rs_loc_idx = rs_pc_i[PC_LSB +: LOC_IDX_W];
  assign lk_cho_idx = lk_pc_i[PC_LSB +: CHO_IDX_W];
  assign rs_cho_idx = rs_pc_i[PC_LSB +: CHO_IDX_W];
  assign lk_lh_idx  = lk_pc_i[PC_LSB +: LH_IDX_W];
  assign rs_lh_idx  = rs_pc_i[PC_LSB +: LH_IDX_W];

  // histories
  logic [GH_W-1:0] ghr;
  logic [LH_W-1:0] lk_lh, rs_lh;

  bp_ghr #(.HIST_W(GH_W)) i_ghr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (rs_valid_i),
    .bit_i      (rs_taken_i),
    .hist_o     (ghr)
  );

  bp_hist_table #(.IDX_W(LH_IDX_W), .HIST_W(LH_W)) i_lhist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (lk_lh_idx),
    .rd_hist_o (lk_lh),
    .up_idx_i  (rs_lh_idx),
    .up_hist_o (rs_lh),
    .up_en_i   (rs_valid_i),
    .up_bit_i  (rs_taken_i)
  );

  logic [COR_IDX_W-1:0] lk_cor_idx, rs_cor_idx;
  assign lk_cor_idx = {ghr, lk_lh};
  assign rs_cor_idx = {ghr, rs_lh};

  // counter tables
  ctr_t lk_loc_ctr, rs_loc_ctr, lk_cor_ctr, rs_cor_ctr, lk_cho_ctr, rs_cho_ctr;
  logic loc_ok, cor_ok, cho_up_en;

  bp_ctr_table #(.IDX_W(LOC_IDX_W)) i_loc_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lk_loc_idx),
    .rd_ctr_o   (lk_loc_ctr),
    .up_idx_i   (rs_loc_idx),
    .up_ctr_o   (rs_loc_ctr),
    .up_en_i    (rs_valid_i),
    .up_taken_i (rs_taken_i)
  );

  bp_ctr_table #(.IDX_W(COR_IDX_W)) i_cor_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lk_cor_idx),
    .rd_ctr_o   (lk_cor_ctr),
    .up_idx_i   (rs_cor_idx),
    .up_ctr_o   (rs_cor_ctr),
    .up_en_i    (rs_valid_i),
    .up_taken_i (rs_taken_i)
  );

  // chooser: MSB=1 favours correlating table
  assign loc_ok    = (rs_loc_ctr[1] == rs_taken_i);
  assign cor_ok    = (rs_cor_ctr[1] == rs_taken_i);
  assign cho_up_en = rs_valid_i && (loc_ok != cor_ok);

  bp_ctr_table #(.IDX_W(CHO_IDX_W)) i_cho_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lk_cho_idx),
    .rd_ctr_o   (lk_cho_ctr),
    .up_idx_i   (rs_cho_idx),
    .up_ctr_o   (rs_cho_ctr),
    .up_en_i    (cho_up_en),
    .up_taken_i (cor_ok)
  );

  assign lk_taken_o = lk_cho_ctr[1] ? lk_cor_ctr[1] : lk_loc_ctr[1];

  // flush request
  logic flush_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else         flush_q <= rs_valid_i && (rs_taken_i != rs_pred_i);
  end
  assign flush_o = flush_q;

  // R9
  flush_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_valid_i && (rs_taken_i != rs_pred_i) |=> flush_o);
  // R9
  flush_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rs_valid_i && (rs_taken_i != rs_pred_i)) |=> !flush_o);
  // R7
  cho_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_valid_i && (rs_loc_ctr[1] == rs_cor_ctr[1]) && (lk_cho_idx == rs_cho_idx)
    |=> $stable(lk_cho_idx) |-> lk_cho_ctr == $past(lk_cho_ctr));
endmodule

// File: tb/test_tournament_bp.sv
`timescale 1ns/1ps
module test_tournament_bp;
  localparam int PC_W = 32, LOC_W = 6, CHO_W = 6, LHI_W = 5, GH_W = 4, LH_W = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [PC_W-1:0] lk_pc, rs_pc;
  logic lk_taken, rs_valid, rs_taken, rs_pred, flush;

  tournament_bp i_tournament_bp (
    .clk_i(clk), .rst_ni(rst_n), .lk_pc_i(lk_pc), .lk_taken_o(lk_taken),
    .rs_valid_i(rs_valid), .rs_pc_i(rs_pc), .rs_taken_i(rs_taken),
    .rs_pred_i(rs_pred), .flush_o(flush)
  );

  int total = 0, bad = 0;

  // reference model
  logic [1:0]      m_loc [1<<LOC_W];
  logic [1:0]      m_cho [1<<CHO_W];
  logic [1:0]      m_cor [1<<(GH_W+LH_W)];
  logic [LH_W-1:0] m_lh  [1<<LHI_W];
  logic [GH_W-1:0] m_ghr;
  logic            m_mis_prev;

  typedef struct { logic lk; logic fl; string tag; } item_t;
  item_t sb_q[$];

  function automatic logic [1:0] sat(logic [1:0] c, logic t);
    if (t) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  function automatic logic m_predict(logic [PC_W-1:0] pc);
    logic [LH_W-1:0] lh;
    lh = m_lh[pc[2 +: LHI_W]];
    if (m_cho[pc[2 +: CHO_W]][1]) return m_cor[{m_ghr, lh}][1];
    return m_loc[pc[2 +: LOC_W]][1];
  endfunction

  task automatic m_update(logic [PC_W-1:0] pc, logic t);
    logic [LH_W-1:0] lh;
    logic [LH_W:0] lsh;
    logic [GH_W:0] gsh;
    logic lp, cp;
    lh = m_lh[pc[2 +: LHI_W]];
    lp = m_loc[pc[2 +: LOC_W]][1];
    cp = m_cor[{m_ghr, lh}][1];
    if (lp != cp) m_cho[pc[2 +: CHO_W]] = sat(m_cho[pc[2 +: CHO_W]], cp == t);
    m_loc[pc[2 +: LOC_W]] = sat(m_loc[pc[2 +: LOC_W]], t);
    m_cor[{m_ghr, lh}] = sat(m_cor[{m_ghr, lh}], t);
    lsh = {lh, t};
    m_lh[pc[2 +: LHI_W]] = lsh[LH_W-1:0];
    gsh = {m_ghr, t};
    m_ghr = gsh[GH_W-1:0];
  endtask

  task automatic m_reset();
    foreach (m_loc[i]) m_loc[i] = 2'b01;
    foreach (m_cho[i]) m_cho[i] = 2'b01;
    foreach (m_cor[i]) m_cor[i] = 2'b01;
    foreach (m_lh[i])  m_lh[i]  = '0;
    m_ghr = '0;
    m_mis_prev = 1'b0;
  endtask

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one cycle per call
  task automatic step(logic [PC_W-1:0] lpc, logic rv, logic [PC_W-1:0] rpc,
                      logic rt, logic rp, string tag);
    item_t it;
    @(posedge clk); #1;
    lk_pc = lpc; rs_valid = rv; rs_pc = rpc; rs_taken = rt; rs_pred = rp;
    it.lk = m_predict(lpc);
    it.fl = m_mis_prev;
    it.tag = tag;
    sb_q.push_back(it);
    m_mis_prev = rv && (rt != rp);
    if (rv) m_update(rpc, rt);
  endtask

  // resolve pc with outcome t, predicted with the model, lookup same pc
  task automatic train(logic [PC_W-1:0] pc, logic t, string tag);
    step(pc, 1'b1, pc, t, m_predict(pc), tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk({it.tag, " lookup R8"}, lk_taken, it.lk);
      chk({it.tag, " flush R9"}, flush, it.fl);
    end
  end

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_reset();
    rst_n = 1'b0; lk_pc = '0; rs_valid = 1'b0; rs_pc = '0; rs_taken = 1'b0; rs_pred = 1'b0;
    // R1: reset state seen at the ports
    for (int i = 0; i < 8; i++) begin
      lk_pc = 32'h40 * i + 32'h1234;
      #3;
      chk("R1 reset lookup", lk_taken, 1'b0);
      chk("R1 reset flush", flush, 1'b0);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1: first lookups after reset over many pcs
    for (int i = 0; i < 16; i++) step(32'h1000 + 4 * i, 1'b0, '0, 1'b0, 1'b0, "R1");

    // R2 / R10: taken streak then not-taken streak on one pc, lookup same entry as update
    for (int i = 0; i < 6; i++) train(32'h100, 1'b1, "R2 R10");
    for (int i = 0; i < 6; i++) train(32'h100, 1'b0, "R2 R10");
    for (int i = 0; i < 4; i++) train(32'h100, i[0], "R2");

    // R3: aliasing pcs share per-address entries, bits [1:0] ignored
    for (int i = 0; i < 8; i++) begin
      train(32'h200 + (32'h1 << (2 + LOC_W)) * i, 1'b1, "R3");
      step(32'h203, 1'b0, '0, 1'b0, 1'b0, "R3");
    end

    // R6 / R7: alternating branch learned only via history
    for (int i = 0; i < 48; i++) train(32'h340, i[0], "R6 R7");

    // R4: period-three pattern
    for (int i = 0; i < 60; i++) train(32'h480, (i % 3) != 2, "R4");

    // R11: invalid resolutions with garbage, nothing may change
    for (int i = 0; i < 24; i++)
      step(32'h340 + 4 * (i % 4), 1'b0, $urandom, i[0], i[1], "R11");

    // R5: interleaved branches share global history
    for (int i = 0; i < 40; i++) begin
      train(32'h600, i[1], "R5");
      train(32'h704, !i[1], "R5");
    end

    // R9: arbitrary predicted directions
    for (int i = 0; i < 32; i++)
      step(32'h800, 1'b1, 32'h800 + 4 * (i % 3), $urandom_range(0, 1), $urandom_range(0, 1), "R9");

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [PC_W-1:0] pc;
      pc = {$urandom_range(0, 127), 2'b00};
      if ($urandom_range(0, 3) == 0)
        step(pc, 1'b0, $urandom, $urandom_range(0, 1), $urandom_range(0, 1), "R11 mix");
      else
        step({$urandom_range(0, 127), 2'b00}, 1'b1, pc, pc[3] ^ pc[5] ^ m_ghr[0],
             $urandom_range(0, 3) == 0 ? $urandom_range(0, 1) : m_predict(pc), "R7 mix");
    end

    step('0, 1'b0, '0, 1'b0, 1'b0, "R9");
    step('0, 1'b0, '0, 1'b0, 1'b0, "R9");
    @(posedge clk);
    @(negedge clk);
    #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule